// File: doc/BRIEF.md
# Decimating Six-Channel Data Loader

This block accepts a stream of 10-bit codes on one input bus and distributes successive codes across six channel registers. Each channel is held in two stages. A load stage fills one channel per active clock edge during a six-word sequence. An output stage updates all six channels in the same cycle when a transfer is requested. A start strobe arms a sequence, and a direction select picks whether loading runs upward or downward through the channels. An edge select chooses whether words are taken on rising or on falling clock edges.

The output stage also carries a polarity flag. The invert request is captured when a transfer takes place, and it reaches the output flag one transfer later. Downstream converters can therefore switch polarity on a whole line at a time. Only the digital codes and the polarity flag are produced here; conversion and analog scaling sit outside the block.

Top module: `deci6_loader`

## Requirements
- R1: Each word is 10 bits wide with bit 9 as the MSB, and it is stored unmodified. Channel k is presented on `code_o[10k+9:10k]`.
- R2: `start_i` is sampled on an active edge. The first word of the sequence is captured on the next active edge, and the word present at the sampling edge itself is not stored.
- R3: A sequence stores exactly six words on six consecutive active edges and then goes idle. Words presented after that are not stored until the next start.
- R4: With `dir_i` = 0 the words go to channels 0,1,…,5 in that order; with `dir_i` = 1 they go to 5,4,…,0. The direction is taken on the edge that stores the first word.
- R5: With `rise_sel_i` = 1 words are taken on rising clock edges; with `rise_sel_i` = 0 they are taken on falling edges. The select is held static and changed only under reset.
- R6: `xfer_i` is sampled on rising edges. On the following rising edge, all six load-stage words are copied to `code_o` together. Otherwise `code_o` and `pol_o` hold their values.
- R7: `invert_i` is captured on the rising edge that performs a transfer. `pol_o` takes that captured value on the next transfer, so a polarity request becomes visible one transfer late. `pol_o` = 1 means inverted.
- R8: A start sampled while a sequence is running restarts it. The next word goes to the first channel for the direction then in force.
- R9: Channels that the running sequence has not yet written keep their previous load-stage contents. A transfer during a sequence therefore mixes new and old words.
- R10: While `rst` is high, the edges of `clk` clear all load and output codes to 0, clear `pol_o` and the stored invert value, and idle the sequencer. This reset is synchronous and active high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din_i | input | 10 | Input code word |
| start_i | input | 1 | Start-of-sequence strobe |
| xfer_i | input | 1 | Transfer strobe, rising-edge sampled |
| dir_i | input | 1 | Load direction: 0 upward, 1 downward |
| rise_sel_i | input | 1 | Load edge: 1 rising, 0 falling |
| invert_i | input | 1 | Polarity request |
| code_o | output | 60 | Six output-stage codes, channel 0 in the low bits |
| pol_o | output | 1 | Polarity flag of the current output codes |

## Verification
On every edge of both load paths, the assertions check the sequencer's write pointer. They cover the one-edge start latency with the right first channel, the single-channel step in the latched direction, the stop after the sixth word, and staying idle without a start. They also check that the outputs hold unless a transfer was sampled, and that reset clears them. The bench scenarios are needed to show which data ends up in which channel. They also cover mixing old and new words on a mid-sequence transfer, the one-transfer polarity lag, and the restart. Falling-edge capture is shown by changing the data between the falling and the rising edge.

// File: rtl/d6_pkg.sv
package d6_pkg;

  typedef enum logic {
    DIR_ASC  = 1'b0,
    DIR_DESC = 1'b1
  } load_dir_e;

  // Channel written at position pos of a sequence of nch words.
  function automatic int unsigned lane_of(input int unsigned pos,
                                          input int unsigned nch,
                                          input load_dir_e   dir);
    return (dir == DIR_DESC) ? (nch - 1 - pos) : pos;
  endfunction

endpackage

// File: rtl/d6_load_path.sv
module d6_load_path
  import d6_pkg::*;
#(
  parameter int DW      = 10,
  parameter int NCH     = 6,
  parameter bit FALLING = 1'b0,
  localparam int PW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DW-1:0]     din,
  input  logic              start_i,
  input  logic              dir_i,
  output logic [NCH*DW-1:0] load_o,
  output logic              wr_en_o,
  output logic [PW-1:0]     wr_idx_o,
  output logic              seq_dir_o
);

  localparam logic [PW-1:0] LAST = PW'(NCH - 1);

  logic            start_q;
  logic            busy_q;
  logic [PW-1:0]   pos_q;
  load_dir_e       dir_q;
  logic [DW-1:0]   bank_q [NCH];

  load_dir_e       eff_dir;
  logic [PW-1:0]   pos;
  logic            wr_en;
  logic [PW-1:0]   wr_idx;
  logic            busy_n;
  logic [PW-1:0]   pos_n;

  // Next write decided from the state left by the previous active edge.
  always_comb begin
    eff_dir = start_q ? load_dir_e'(dir_i) : dir_q;
    pos     = start_q ? '0 : pos_q;
    wr_en   = start_q | busy_q;
    wr_idx  = PW'(lane_of(pos, NCH, eff_dir));
    busy_n  = wr_en && (pos != LAST);
    pos_n   = wr_en ? pos + 1'b1 : pos_q;
  end

  generate
    if (FALLING) begin : g_neg
      always_ff @(negedge clk) begin
        if (rst) begin
          start_q <= 1'b0;
          busy_q  <= 1'b0;
          pos_q   <= '0;
          dir_q   <= DIR_ASC;
          for (int k = 0; k < NCH; k++) bank_q[k] <= '0;
        end else begin
          start_q <= start_i;
          busy_q  <= busy_n;
          pos_q   <= pos_n;
          dir_q   <= eff_dir;
          if (wr_en) bank_q[wr_idx] <= din;
        end
      end
    end else begin : g_pos
      always_ff @(posedge clk) begin
        if (rst) begin
          start_q <= 1'b0;
          busy_q  <= 1'b0;
          pos_q   <= '0;
          dir_q   <= DIR_ASC;
          for (int k = 0; k < NCH; k++) bank_q[k] <= '0;
        end else begin
          start_q <= start_i;
          busy_q  <= busy_n;
          pos_q   <= pos_n;
          dir_q   <= eff_dir;
          if (wr_en) bank_q[wr_idx] <= din;
        end
      end
    end

    for (genvar k = 0; k < NCH; k++) begin : g_flat
      assign load_o[k*DW +: DW] = bank_q[k];
    end
  endgenerate

  assign wr_en_o   = wr_en;
  assign wr_idx_o  = wr_idx;
  assign seq_dir_o = (eff_dir == DIR_DESC);

endmodule

// File: rtl/d6_out_stage.sv
module d6_out_stage #(
  parameter int DW  = 10,
  parameter int NCH = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH*DW-1:0] load_i,
  input  logic              xfer_i,
  input  logic              inv_i,
  output logic [NCH*DW-1:0] code_o,
  output logic              pol_o
);

  logic              xfer_q;
  logic              inv_hold_q;
  logic [NCH*DW-1:0] code_q;
  logic              pol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_q     <= 1'b0;
      inv_hold_q <= 1'b0;
      code_q     <= '0;
      pol_q      <= 1'b0;
    end else begin
      xfer_q <= xfer_i;
      if (xfer_q) begin
        code_q     <= load_i;
        pol_q      <= inv_hold_q;
        inv_hold_q <= inv_i;
      end
    end
  end

  assign code_o = code_q;
  assign pol_o  = pol_q;

endmodule

// File: rtl/deci6_loader.sv
module deci6_loader #(
  parameter int DW  = 10,
  parameter int NCH = 6,
  localparam int PW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DW-1:0]     din_i,
  input  logic              start_i,
  input  logic              xfer_i,
  input  logic              dir_i,
  input  logic              rise_sel_i,
  input  logic              invert_i,
  output logic [NCH*DW-1:0] code_o,
  output logic              pol_o
);

  logic [NCH*DW-1:0] r_load, f_load, sel_load;
  logic              r_wr_en, f_wr_en;
  logic [PW-1:0]     r_wr_idx, f_wr_idx;
  logic              r_seq_dir, f_seq_dir;

  d6_load_path #(.DW(DW), .NCH(NCH), .FALLING(1'b0)) u_rise (
    .clk(clk), .rst(rst), .din(din_i), .start_i(start_i), .dir_i(dir_i),
    .load_o(r_load), .wr_en_o(r_wr_en), .wr_idx_o(r_wr_idx),
    .seq_dir_o(r_seq_dir)
  );

  d6_load_path #(.DW(DW), .NCH(NCH), .FALLING(1'b1)) u_fall (
    .clk(clk), .rst(rst), .din(din_i), .start_i(start_i), .dir_i(dir_i),
    .load_o(f_load), .wr_en_o(f_wr_en), .wr_idx_o(f_wr_idx),
    .seq_dir_o(f_seq_dir)
  );

  assign sel_load = rise_sel_i ? r_load : f_load;

  d6_out_stage #(.DW(DW), .NCH(NCH)) u_out (
    .clk(clk), .rst(rst), .load_i(sel_load), .xfer_i(xfer_i),
    .inv_i(invert_i), .code_o(code_o), .pol_o(pol_o)
  );

endmodule

// File: rtl/d6_chk.sv
module d6_path_chk #(
  parameter int NCH = 6,
  localparam int PW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic          ck,
  input logic          rst,
  input logic          start_i,
  input logic          dir_i,
  input logic          wr_en,
  input logic [PW-1:0] wr_idx,
  input logic          seq_dir
);
  localparam logic [PW-1:0] LAST = PW'(NCH - 1);

  // R2 with R4: first write one active edge after start, at the first channel
  p_start_lat_r2: assert property (@(posedge ck) disable iff (rst)
    start_i |=> (wr_en && (wr_idx == (dir_i ? LAST : '0))));

  // R4: step by one channel in the latched direction
  p_step_dir_r4: assert property (@(posedge ck) disable iff (rst)
    (wr_en && !start_i && (wr_idx != (seq_dir ? '0 : LAST))) |=>
      (wr_en && (seq_dir == $past(seq_dir)) &&
       (wr_idx == (seq_dir ? $past(wr_idx) - 1'b1 : $past(wr_idx) + 1'b1))));

  // R3: stop after the last channel
  p_seq_end_r3: assert property (@(posedge ck) disable iff (rst)
    (wr_en && !start_i && (wr_idx == (seq_dir ? '0 : LAST))) |=> !wr_en);

  // R3: idle stays idle without a start
  p_idle_r3: assert property (@(posedge ck) disable iff (rst)
    (!wr_en && !start_i) |=> !wr_en);
endmodule

module d6_top_chk #(
  parameter int DW  = 10,
  parameter int NCH = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_i,
  input logic [NCH*DW-1:0] code_o,
  input logic              pol_o
);
  // R10: reset clears the output stage
  p_reset_clr_r10: assert property (@(posedge clk)
    rst |=> ((code_o == '0) && !pol_o));

  // R6: without a sampled transfer the outputs hold
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !xfer_i |=> ##1 ($stable(code_o) && $stable(pol_o)));
endmodule

bind deci6_loader d6_top_chk #(.DW(DW), .NCH(NCH)) u_top_chk (
  .clk(clk), .rst(rst), .xfer_i(xfer_i), .code_o(code_o), .pol_o(pol_o)
);

bind deci6_loader d6_path_chk #(.NCH(NCH)) u_rise_chk (
  .ck(clk), .rst(rst), .start_i(start_i), .dir_i(dir_i),
  .wr_en(r_wr_en), .wr_idx(r_wr_idx), .seq_dir(r_seq_dir)
);

bind deci6_loader d6_path_chk #(.NCH(NCH)) u_fall_chk (
  .ck(~clk), .rst(rst), .start_i(start_i), .dir_i(dir_i),
  .wr_en(f_wr_en), .wr_idx(f_wr_idx), .seq_dir(f_seq_dir)
);

// File: tb/test_deci6_loader.sv
module test_deci6_loader;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  din_i = '0;
  logic        start_i = 1'b0, xfer_i = 1'b0, dir_i = 1'b0;
  logic        rise_sel_i = 1'b1, invert_i = 1'b0;
  logic [59:0] code_o;
  logic        pol_o;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string tag = "R10";

  deci6_loader i_deci6_loader (
    .clk(clk), .rst(rst), .din_i(din_i), .start_i(start_i),
    .xfer_i(xfer_i), .dir_i(dir_i), .rise_sel_i(rise_sel_i),
    .invert_i(invert_i), .code_o(code_o), .pol_o(pol_o)
  );

  always #10 clk = ~clk;

  // behavioural reference
  logic [9:0] m_bank [6];
  logic [9:0] m_out  [6];
  bit m_pend = 0, m_down = 0, m_xq = 0, m_invh = 0, m_pol = 0;
  int m_left = 0, m_next = 0;

  initial for (int k = 0; k < 6; k++) begin m_bank[k] = '0; m_out[k] = '0; end

  task automatic m_load_edge();
    if (rst) begin
      m_pend = 0; m_left = 0; m_next = 0; m_down = 0;
      for (int k = 0; k < 6; k++) m_bank[k] = '0;
    end else begin
      if (m_pend) begin
        m_down = dir_i; m_next = dir_i ? 5 : 0; m_left = 6;
      end
      if (m_left > 0) begin
        m_bank[m_next] = din_i;
        m_next += m_down ? -1 : 1;
        m_left--;
      end
      m_pend = start_i;
    end
  endtask

  task automatic m_out_edge();
    if (rst) begin
      m_xq = 0; m_invh = 0; m_pol = 0;
      for (int k = 0; k < 6; k++) m_out[k] = '0;
    end else begin
      if (m_xq) begin
        for (int k = 0; k < 6; k++) m_out[k] = m_bank[k];
        m_pol  = m_invh;
        m_invh = invert_i;
      end
      m_xq = xfer_i;
    end
  endtask

  task automatic compare_cycle();
    logic [59:0] e;
    for (int k = 0; k < 6; k++) e[k*10 +: 10] = m_out[k];
    checks++;
    if (e !== code_o || m_pol !== pol_o) begin
      errors++;
      $display("FAIL %s cycle compare: code %h pol %b expected code %h pol %b",
               tag, code_o, pol_o, e, m_pol);
    end
  endtask

  // one clock: called at posedge+5, returns at next posedge+5
  task automatic cyc(input logic [9:0] d, input logic s, input logic x);
    din_i = d; start_i = s; xfer_i = x;
    @(negedge clk); #1;
    if (!rise_sel_i) begin
      m_load_edge();
      din_i = ~d;  // R5: a rising-edge capture would see this value
    end
    @(posedge clk); #1;
    m_out_edge();
    if (rise_sel_i) m_load_edge();
    #2 compare_cycle();
    #2;
  endtask

  task automatic chk_ch(input string t, input int ch, input logic [9:0] exp);
    checks++;
    if (code_o[ch*10 +: 10] !== exp) begin
      errors++;
      $display("FAIL %s channel %0d: got %h expected %h", t, ch, code_o[ch*10 +: 10], exp);
    end
  endtask

  task automatic chk_pol(input string t, input logic exp);
    checks++;
    if (pol_o !== exp) begin
      errors++;
      $display("FAIL %s polarity: got %b expected %b", t, pol_o, exp);
    end
  endtask

  task automatic seq_load(input logic [9:0] base);
    cyc(10'h155, 1'b1, 1'b0);
    for (int k = 0; k < 6; k++) cyc(base + 10'(k), 1'b0, 1'b0);
  endtask

  task automatic do_xfer();
    cyc(10'h0, 1'b0, 1'b1);
    cyc(10'h0, 1'b0, 1'b0);
  endtask

  initial begin
    @(posedge clk); #5;
    // R10: reset state
    tag = "R10";
    for (int i = 0; i < 3; i++) cyc(10'h3FF, 1'b1, 1'b1);
    for (int k = 0; k < 6; k++) chk_ch("R10 reset", k, 10'h000);
    chk_pol("R10 reset", 1'b0);
    rst = 1'b0;
    cyc(10'h0, 1'b0, 1'b0);

    // R1 R2 R4: upward load, rising edges
    tag = "R2"; dir_i = 1'b0;
    seq_load(10'h200);
    do_xfer();
    for (int k = 0; k < 6; k++) chk_ch("R4 upward", k, 10'h200 + 10'(k));
    chk_ch("R2 start word not stored", 0, 10'h200);
    checks++;
    if (code_o[9] !== 1'b1 || code_o[8:0] !== 9'h0) begin
      errors++;
      $display("FAIL R1 bit order: got %h expected %h", code_o[9:0], 10'h200);
    end

    // R3: words after the sixth are ignored
    tag = "R3";
    for (int i = 0; i < 4; i++) cyc(10'h3AA, 1'b0, 1'b0);
    do_xfer();
    chk_ch("R3 after end ch5", 5, 10'h205);
    chk_ch("R3 after end ch0", 0, 10'h200);

    // R4 downward, and R6 hold before transfer
    tag = "R4"; dir_i = 1'b1;
    seq_load(10'h040);
    cyc(10'h0, 1'b0, 1'b0);
    cyc(10'h0, 1'b0, 1'b0);
    chk_ch("R6 hold without transfer", 0, 10'h200);
    do_xfer();
    chk_ch("R4 downward ch5", 5, 10'h040);
    chk_ch("R4 downward ch0", 0, 10'h045);

    // R9: transfer in the middle of a sequence
    tag = "R9"; dir_i = 1'b0;
    cyc(10'h155, 1'b1, 1'b0);
    cyc(10'h300, 1'b0, 1'b0);
    cyc(10'h301, 1'b0, 1'b0);
    cyc(10'h302, 1'b0, 1'b1);
    cyc(10'h303, 1'b0, 1'b0);
    chk_ch("R9 new ch2", 2, 10'h302);
    chk_ch("R9 old ch3", 3, 10'h042);
    chk_ch("R9 old ch5", 5, 10'h040);
    cyc(10'h304, 1'b0, 1'b0);
    cyc(10'h305, 1'b0, 1'b0);

    // R8: restart while running
    tag = "R8";
    cyc(10'h1AB, 1'b1, 1'b0);
    cyc(10'h100, 1'b0, 1'b0);
    cyc(10'h101, 1'b1, 1'b0);
    for (int k = 0; k < 6; k++) cyc(10'h110 + 10'(k), 1'b0, 1'b0);
    do_xfer();
    for (int k = 0; k < 6; k++) chk_ch("R8 restart", k, 10'h110 + 10'(k));

    // R7: polarity lags one transfer
    tag = "R7";
    invert_i = 1'b1;
    do_xfer();
    chk_pol("R7 first transfer keeps old polarity", 1'b0);
    invert_i = 1'b0;
    do_xfer();
    chk_pol("R7 second transfer shows inversion", 1'b1);
    do_xfer();
    chk_pol("R7 third transfer clears inversion", 1'b0);

    // R5: falling-edge loading, switched under reset
    tag = "R10"; rise_sel_i = 1'b0; rst = 1'b1;
    for (int i = 0; i < 3; i++) cyc(10'h0, 1'b0, 1'b0);
    chk_ch("R10 clears after use", 0, 10'h000);
    rst = 1'b0;
    tag = "R5"; dir_i = 1'b0;
    seq_load(10'h3C0);
    do_xfer();
    for (int k = 0; k < 6; k++) chk_ch("R5 falling edge", k, 10'h3C0 + 10'(k));
    dir_i = 1'b1;
    seq_load(10'h080);
    do_xfer();
    chk_ch("R5 falling downward ch5", 5, 10'h080);
    chk_ch("R5 falling downward ch0", 0, 10'h085);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule